// File: doc/BRIEF.md
# Single-Precision Normalise, Round and Pack Stage

This block is the last stage of a single-precision arithmetic pipeline. An upstream datapath hands it an intermediate result in unpacked form: a sign, a signed extended exponent, a 32-bit significand that keeps eight bits below the final kept LSB, and the exception flags already raised. The block turns this into the packed 32-bit word and the final flags. It brings the leading one to the top of the significand and shifts tiny values into the denormal range without losing any set bit. It rounds in one of four modes and reports overflow, underflow and inexact.

The intermediate exponent is biased one below the packed exponent field. A significand of 0x80000000 with exponent 126 packs to 1.0 (0x3F800000), because the hidden bit is added into the exponent field by the packing sum. The result is registered once. `out_valid` follows `in_valid` by one clock, and the output registers keep their value while `in_valid` is low.

Top module: `sfp_round_pack`

## Requirements
- R1: When `in_exp` equals 255 and either `in_sig` is zero or `in_flags` is nonzero, the word is packed unrounded as {sign, (255<<23) + (in_sig>>7)} and the flags pass through unchanged.
- R2: A zero `in_sig` (outside the R1 case) yields a zero of the input sign (word bits 30:0 all zero), and the flags pass through unchanged.
- R3: The significand is shifted left until bit 31 is set, and the exponent drops by the shift amount. Equal values given with different shifts pack to the same word.
- R4: If the normalised exponent is negative, the significand is shifted right by its magnitude, ORing every lost bit into bit 0, and the exponent becomes 0. An exact denormal raises no flag.
- R5: `rnd_mode` encoding: 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero. The nearest mode adds 0x80, or 0x7F when bit 8 is clear. The directed modes add 0xFF when rounding away from zero for the sign, and 0 otherwise. Toward zero adds 0.
- R6: If adding the increment carries out of bit 31, the exponent rises by one, the significand shifts right by one keeping its old bit 0 as sticky, and the increment is halved before it is added.
- R7: Inexact (flag bit 0) is set whenever bits 7:0 are nonzero just before the increment is added.
- R8: An exponent of 254 or more at rounding sets overflow (bit 2) and inexact. The word is max finite (magnitude 0x7F7FFFFF) when the increment is zero, and infinity (0x7F800000) otherwise.
- R9: Underflow (bit 1) is set only for a tiny value with nonzero low bits after denormalising, whose rounded result still has a zero exponent and a significand of at most 0x80000000.
- R10: `out_flags` is {invalid, overflow, underflow, inexact} in bits 3..0, ORed with `in_flags`. The word is {sign, (exp<<23) + (significand>>8)}.
- R11: After reset `out_valid`, `out_word` and `out_flags` are 0. `out_valid` equals `in_valid` one clock later, and the outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input result is present |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EXP_W (12) | Signed extended exponent, biased one below the field |
| in_sig | input | 32 | Significand with eight low rounding bits |
| in_flags | input | 4 | Flags already raised, {invalid, overflow, underflow, inexact} |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Output word is present |
| out_word | output | 32 | Packed single-precision result |
| out_flags | output | 4 | Final flags, same order as `in_flags` |

## Verification
The rounding carry and overflow detection can fall in the same cycle. An exponent of 253 with an all-ones significand carries on rounding to nearest and crosses into the overflow range. The bench expects infinity with overflow and inexact there. Round toward zero on the same input must give max finite with only inexact. A second coincidence, denormalisation together with round-up into the smallest normal, is judged by underflow clearing. An exhaustive sweep over exponents from -40 to 270, both signs, all modes and a set of edge significands compares every result with an arithmetic model in the bench.

// File: rtl/sfp_rp_pkg.sv
// Package: constants and types shared by the normalise/round/pack stage.
// Assumes a 32-bit significand with eight bits below the kept LSB.
package sfp_rp_pkg;
    localparam int SIG_W     = 32;           // significand width
    localparam int GRD_W     = 7;            // guard field below the packed mantissa
    localparam int RB_W      = GRD_W + 1;    // bits dropped by the final pack
    localparam int EXP_W     = 12;           // signed extended exponent width
    localparam int FEXP_W    = 8;            // packed exponent field
    localparam int MANT_W    = 23;           // packed mantissa field
    localparam int EXP_SPEC  = 255;          // infinity / NaN exponent
    localparam int EXP_OVF   = 254;          // overflow threshold
    localparam int EXP_MAXF  = 253;          // exponent giving max finite
    localparam int NFLAG     = 4;

    // flag bit positions
    localparam int FL_IXC = 0;
    localparam int FL_UFC = 1;
    localparam int FL_OFC = 2;
    localparam int FL_IOC = 3;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;
endpackage

// File: rtl/sfp_lzc.sv
// Leading-zero counter. Returns W when the vector is all zero.
// Assumes nothing about the input.
module sfp_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // scan from LSB upward; the last set bit found is the most significant
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/sfp_norm_stage.sv
// Classifies the input, normalises the significand to bit 31 and, for a
// negative exponent, denormalises it with a sticky right shift.
// Assumes the input exponent leaves room for subtracting SIG_W.
module sfp_norm_stage
    import sfp_rp_pkg::*;
#(
    parameter int SW = SIG_W,
    parameter int EW = EXP_W,
    parameter int RB = RB_W
) (
    input  logic                 pending,
    input  logic signed [EW-1:0] in_exp,
    input  logic [SW-1:0]        in_sig,
    output logic                 is_pass,
    output logic                 is_zero,
    output logic                 tiny,
    output logic signed [EW-1:0] n_exp,
    output logic [SW-1:0]        n_sig,
    output logic                 uf_cand
);
    localparam int CW = $clog2(SW) + 1;

    logic [CW-1:0]        lz;
    logic [SW-1:0]        sh_sig;
    logic signed [EW-1:0] sh_exp;
    logic [EW-1:0]        amt;
    logic [SW-1:0]        den;

    sfp_lzc #(.W(SW), .CW(CW)) lzc_i (.vec(in_sig), .cnt(lz));

    // classify pass-through and zero inputs
    always_comb begin
        is_zero = (in_sig == '0);
        is_pass = (in_exp == EW'(EXP_SPEC)) && (is_zero || pending);
    end

    // normalise, then jam-shift tiny values into the denormal range
    always_comb begin
        sh_sig  = in_sig << lz;
        sh_exp  = in_exp - EW'(lz);
        tiny    = sh_exp[EW-1];
        amt     = EW'(0) - sh_exp;
        den     = (sh_sig >> amt) | SW'(|(sh_sig & ~({SW{1'b1}} << amt)));
        n_exp   = tiny ? '0 : sh_exp;
        n_sig   = tiny ? den : sh_sig;
        uf_cand = tiny && (|den[RB-1:0]);
    end
endmodule

// File: rtl/sfp_round_core.sv
// Picks the rounding increment, renormalises on carry-out, adds it, and
// decides overflow, underflow and inexact. Assumes a normalised or
// denormalised significand and a non-negative exponent.
module sfp_round_core
    import sfp_rp_pkg::*;
#(
    parameter int SW = SIG_W,
    parameter int EW = EXP_W,
    parameter int RB = RB_W
) (
    input  logic                 sign,
    input  rmode_e               mode,
    input  logic signed [EW-1:0] exp_in,
    input  logic [SW-1:0]        sig_in,
    input  logic                 uf_cand,
    output logic [FEXP_W-1:0]    r_exp,
    output logic [SW-1:0]        r_sig,
    output logic                 ovf,
    output logic                 ixc,
    output logic                 ufc
);
    localparam logic [SW-1:0] HALF = SW'(1) << (RB - 1);
    localparam logic [SW-1:0] ALL  = (SW'(1) << RB) - SW'(1);
    localparam logic [SW-1:0] MAXS = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] TOPB = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0]        incr, incr2, sig2, sig3;
    logic [SW:0]          sum;
    logic                 carry;
    logic signed [EW-1:0] exp2, fexp;

    // mode-dependent increment
    always_comb begin
        case (mode)
            RM_NEAR: incr = sig_in[RB] ? HALF : HALF - SW'(1);
            RM_ZERO: incr = '0;
            default: incr = ((mode == RM_UP) ^ sign) ? ALL : '0;
        endcase
    end

    // carry-out renormalisation and the increment itself
    always_comb begin
        sum   = {1'b0, sig_in} + {1'b0, incr};
        carry = sum[SW];
        exp2  = carry ? exp_in + EW'(1) : exp_in;
        sig2  = carry ? ({1'b0, sig_in[SW-1:1]} | SW'(sig_in[0])) : sig_in;
        incr2 = carry ? (incr >> 1) : incr;
        sig3  = carry ? sig2 + incr2 : sum[SW-1:0];
    end

    // overflow, underflow, inexact and final fields
    always_comb begin
        ovf  = (exp2 >= $signed(EW'(EXP_OVF)));
        fexp = (sig3[SW-1:RB] == '0) ? '0 : exp2;
        if (ovf) begin
            ixc   = 1'b1;
            ufc   = 1'b0;
            r_exp = (incr2 == '0) ? FEXP_W'(EXP_MAXF) : FEXP_W'(EXP_SPEC);
            r_sig = (incr2 == '0) ? MAXS : '0;
        end else begin
            ixc   = |sig2[RB-1:0];
            ufc   = uf_cand && !((fexp != '0) || (sig3 > TOPB));
            r_exp = fexp[FEXP_W-1:0];
            r_sig = sig3 >> 1;
        end
    end
endmodule

// File: rtl/sfp_pack.sv
// Packs sign, exponent field and significand into a single-precision
// word; the hidden bit at significand bit 30 carries into the exponent.
module sfp_pack
    import sfp_rp_pkg::*;
#(
    parameter int SW = SIG_W
) (
    input  logic              sign,
    input  logic [FEXP_W-1:0] exp_f,
    input  logic [SW-1:0]     sig,
    output logic [31:0]       word
);
    // sum exponent and shifted significand through the carry
    always_comb begin
        word = {sign, {exp_f, MANT_W'(0)} + 31'(sig >> GRD_W)};
    end
endmodule

// File: rtl/sfp_round_pack.sv
// Top: normalise, round and pack an unpacked single-precision result,
// registered once. Assumes the exponent is biased one below the field
// and lies well inside the signed EXP_W range.
module sfp_round_pack
    import sfp_rp_pkg::*;
#(
    parameter int EXP_W_P = EXP_W,
    parameter int SIG_W_P = SIG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_sign,
    input  logic signed [EXP_W_P-1:0] in_exp,
    input  logic [SIG_W_P-1:0]        in_sig,
    input  logic [NFLAG-1:0]          in_flags,
    input  logic [1:0]                rnd_mode,
    output logic                      out_valid,
    output logic [31:0]               out_word,
    output logic [NFLAG-1:0]          out_flags
);
    logic                      is_pass, is_zero, tiny, uf_cand;
    logic signed [EXP_W_P-1:0] n_exp;
    logic [SIG_W_P-1:0]        n_sig, rc_sig, mx_sig;
    logic [FEXP_W-1:0]         rc_exp, mx_exp;
    logic                      rc_ovf, rc_ixc, rc_ufc;
    logic [NFLAG-1:0]          mx_flags;
    logic [31:0]               pk_word;

    sfp_norm_stage #(.SW(SIG_W_P), .EW(EXP_W_P), .RB(RB_W)) norm_i (
        .pending (|in_flags),
        .in_exp  (in_exp),
        .in_sig  (in_sig),
        .is_pass (is_pass),
        .is_zero (is_zero),
        .tiny    (tiny),
        .n_exp   (n_exp),
        .n_sig   (n_sig),
        .uf_cand (uf_cand)
    );

    sfp_round_core #(.SW(SIG_W_P), .EW(EXP_W_P), .RB(RB_W)) round_i (
        .sign    (in_sign),
        .mode    (rmode_e'(rnd_mode)),
        .exp_in  (n_exp),
        .sig_in  (n_sig),
        .uf_cand (uf_cand),
        .r_exp   (rc_exp),
        .r_sig   (rc_sig),
        .ovf     (rc_ovf),
        .ixc     (rc_ixc),
        .ufc     (rc_ufc)
    );

    // select pass-through, zero or rounded fields and flags
    always_comb begin
        if (is_pass) begin
            mx_exp   = in_exp[FEXP_W-1:0];
            mx_sig   = in_sig;
            mx_flags = in_flags;
        end else if (is_zero) begin
            mx_exp   = '0;
            mx_sig   = '0;
            mx_flags = in_flags;
        end else begin
            mx_exp   = rc_exp;
            mx_sig   = rc_sig;
            mx_flags = in_flags;
            mx_flags[FL_OFC] = in_flags[FL_OFC] | rc_ovf;
            mx_flags[FL_UFC] = in_flags[FL_UFC] | rc_ufc;
            mx_flags[FL_IXC] = in_flags[FL_IXC] | rc_ixc;
        end
    end

    sfp_pack #(.SW(SIG_W_P)) pack_i (
        .sign  (in_sign),
        .exp_f (mx_exp),
        .sig   (mx_sig),
        .word  (pk_word)
    );

    // output register with valid follow and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word  <= pk_word;
                out_flags <= mx_flags;
            end
        end
    end

    // R11: valid follows with one cycle latency, outputs hold when idle
    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && $stable(out_flags)));
    // R3: a normal (non-tiny) nonzero value reaches rounding with bit 31 set
    p_norm_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_zero && !tiny) |-> n_sig[SIG_W_P-1]);
    // R4: a denormalised significand never keeps the top bit
    p_tiny_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_zero && tiny) |-> !n_sig[SIG_W_P-1]);
    // R6: a rounded non-overflow result with nonzero exponent keeps its hidden bit
    p_hidden_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_zero && !rc_ovf && rc_exp != '0) |-> rc_sig[SIG_W_P-2]);
    // R8: an overflow packs to infinity or max finite
    p_ovf_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_pass && !is_zero && rc_ovf) |->
        (pk_word[30:0] == 31'h7F800000 || pk_word[30:0] == 31'h7F7FFFFF));
    // R9: underflow is only raised together with inexact
    p_uf_ixc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rc_ufc) |-> rc_ixc);
    // R2: a zero significand packs a signed zero
    p_zero_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_zero && !is_pass) |-> (pk_word[30:0] == '0));
endmodule

// File: tb/sfp_round_pack_tb.sv
`timescale 1ns/1ps
module sfp_round_pack_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_sign = 1'b0;
    logic signed [11:0] in_exp = '0;
    logic [31:0]        in_sig = '0;
    logic [3:0]         in_flags = '0;
    logic [1:0]         rnd_mode = '0;
    logic               out_valid;
    logic [31:0]        out_word;
    logic [3:0]         out_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sfp_round_pack dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_flags(in_flags),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .out_word(out_word),
        .out_flags(out_flags)
    );

    // arithmetic model written from the requirements
    function automatic void ref_model(input bit sg, input int e_in,
            input bit [31:0] s_in, input bit [3:0] fl_in, input bit [1:0] md,
            output bit [31:0] w, output bit [3:0] fl, output string tag);
        longint e;
        longint unsigned s, inc, t;
        bit uf, ixc, ofc, ufc;
        e = e_in; s = s_in; uf = 0; ofc = 0; ufc = 0;
        if (e == 255 && (s == 0 || fl_in != 0)) begin
            w = {sg, 31'((64'd255 << 23) + (s >> 7))}; fl = fl_in; tag = "R1"; return;
        end
        if (s == 0) begin
            w = {sg, 31'b0}; fl = fl_in; tag = "R2"; return;
        end
        tag = "R5";
        while (s < 64'h8000_0000) begin s = s * 2; e = e - 1; end
        if (e < 0) begin
            tag = "R4";
            if (-e >= 40) s = 1;
            else begin
                t = s % (64'd1 << (-e));
                s = s / (64'd1 << (-e));
                if (t != 0) s = s | 1;
            end
            e = 0;
            uf = (s % 256) != 0;
        end
        if (md == 2'b00)      inc = ((s >> 8) & 1) ? 128 : 127;
        else if (md == 2'b11) inc = 0;
        else                  inc = ((md == 2'b01) != sg) ? 255 : 0;
        if (s + inc >= 64'h1_0000_0000) begin
            tag = "R6"; e = e + 1; s = (s / 2) | (s & 1); inc = inc / 2;
        end
        ixc = (s % 256) != 0;
        s = s + inc;
        if (e >= 254) begin
            tag = "R8"; ofc = 1; ixc = 1;
            w = (inc == 0) ? {sg, 31'h7F7FFFFF} : {sg, 31'h7F800000};
        end else begin
            if ((s >> 8) == 0) e = 0;
            if (e == 0 && s <= 64'h8000_0000 && uf) begin ufc = 1; tag = "R9"; end
            w = {sg, 31'((e << 23) + (s >> 8))};
        end
        fl = fl_in | {1'b0, ofc, ufc, ixc};
    endfunction

    task automatic drive(bit sg, int e, bit [31:0] s, bit [3:0] fl, bit [1:0] md);
        in_valid = 1'b1; in_sign = sg; in_exp = 12'(e);
        in_sig = s; in_flags = fl; rnd_mode = md;
        @(negedge clk);
    endtask

    task automatic check(string req, bit [31:0] aw, bit [3:0] af,
                         bit [31:0] ew, bit [3:0] ef);
        n_chk++;
        if (aw !== ew || af !== ef) begin
            n_bad++;
            $display("FAIL %s: word=%08h flags=%04b expected word=%08h flags=%04b",
                     req, aw, af, ew, ef);
        end
    endtask

    // directed vector with a hand-derived expectation
    task automatic dir(string req, bit sg, int e, bit [31:0] s, bit [3:0] fl,
                       bit [1:0] md, bit [31:0] ew, bit [3:0] ef);
        drive(sg, e, s, fl, md);
        check(req, out_word, out_flags, ew, ef);
    endtask

    function automatic bit [31:0] pat(int k);
        case (k)
            0: pat = 32'h80000000;  1: pat = 32'hFFFFFFFF;
            2: pat = 32'h00000001;  3: pat = 32'h80000080;
            4: pat = 32'h80000180;  5: pat = 32'hFFFFFF80;
            6: pat = 32'h40000001;  7: pat = 32'h00012345;
            8: pat = 32'hAAAAAAAA;  9: pat = 32'h7FFFFFC0;
            10: pat = 32'h00000000; default: pat = 32'h12345678;
        endcase
    endfunction

    initial begin
        bit [31:0] ew, held;
        bit [3:0]  ef;
        string     tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 reset", {31'b0, out_valid}, out_flags, 32'h0, 4'h0);
        check("R11 reset word", out_word, 4'h0, 32'h0, 4'h0);
        rst_n = 1'b1;

        // R3 normalisation, R10 packing of 1.0
        dir("R10 one", 0, 126, 32'h80000000, 4'h0, 2'b00, 32'h3F800000, 4'b0000);
        check("R11 latency", {31'b0, out_valid}, 4'h0, 32'h1, 4'h0);
        dir("R3 shift", 0, 157, 32'h00000001, 4'h0, 2'b00, 32'h3F800000, 4'b0000);
        dir("R10 flag or", 0, 126, 32'h80000000, 4'b1000, 2'b00, 32'h3F800000, 4'b1000);
        // R5 modes, R7 inexact
        dir("R5 tie even", 0, 126, 32'h80000080, 4'h0, 2'b00, 32'h3F800000, 4'b0001);
        dir("R5 tie odd", 0, 126, 32'h80000180, 4'h0, 2'b00, 32'h3F800002, 4'b0001);
        dir("R5 up pos", 0, 126, 32'h80000001, 4'h0, 2'b01, 32'h3F800001, 4'b0001);
        dir("R5 down pos", 0, 126, 32'h80000001, 4'h0, 2'b10, 32'h3F800000, 4'b0001);
        dir("R5 down neg", 1, 126, 32'h80000001, 4'h0, 2'b10, 32'hBF800001, 4'b0001);
        dir("R5 up neg", 1, 126, 32'h80000001, 4'h0, 2'b01, 32'hBF800000, 4'b0001);
        dir("R7 zero mode", 0, 126, 32'h80000001, 4'h0, 2'b11, 32'h3F800000, 4'b0001);
        // R6 carry-out
        dir("R6 carry", 0, 126, 32'hFFFFFFFF, 4'h0, 2'b00, 32'h40000000, 4'b0001);
        // R8 overflow, alone and after a carry
        dir("R8 maxf", 0, 254, 32'h80000000, 4'h0, 2'b11, 32'h7F7FFFFF, 4'b0101);
        dir("R8 inf", 0, 254, 32'h80000000, 4'h0, 2'b00, 32'h7F800000, 4'b0101);
        dir("R8 maxf down", 0, 254, 32'h80000000, 4'h0, 2'b10, 32'h7F7FFFFF, 4'b0101);
        dir("R8 carry inf", 0, 253, 32'hFFFFFFFF, 4'h0, 2'b00, 32'h7F800000, 4'b0101);
        dir("R8 no carry", 0, 253, 32'hFFFFFFFF, 4'h0, 2'b11, 32'h7F7FFFFF, 4'b0001);
        // R4 and R9 tiny values
        dir("R4 exact denorm", 0, -1, 32'h80000000, 4'h0, 2'b00, 32'h00400000, 4'b0000);
        dir("R9 underflow", 0, -1, 32'h80000001, 4'h0, 2'b00, 32'h00400000, 4'b0011);
        dir("R9 to min normal", 0, -1, 32'hFFFFFFFF, 4'h0, 2'b00, 32'h00800000, 4'b0001);
        dir("R4 deep up", 0, -100, 32'h80000000, 4'h0, 2'b01, 32'h00000001, 4'b0011);
        dir("R4 deep zero", 0, -100, 32'h80000000, 4'h0, 2'b11, 32'h00000000, 4'b0011);
        // R1 and R2
        dir("R1 inf", 1, 255, 32'h00000000, 4'h0, 2'b00, 32'hFF800000, 4'b0000);
        dir("R1 pending", 0, 255, 32'h20000000, 4'b1000, 2'b00, 32'h7FC00000, 4'b1000);
        dir("R2 neg zero", 1, 77, 32'h00000000, 4'b0100, 2'b01, 32'h80000000, 4'b0100);

        // R11 hold while idle
        held = out_word;
        in_valid = 1'b0; in_sig = 32'h12345678; in_exp = 12'(100);
        @(negedge clk);
        check("R11 idle valid", {31'b0, out_valid}, 4'h0, 32'h0, 4'h0);
        check("R11 hold", out_word, out_flags, held, 4'b0100);

        // exhaustive sweep against the model
        for (int e = -40; e <= 270; e++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int k = 0; k < 12; k++) begin
                        bit [3:0] fl;
                        fl = (k == 7) ? 4'b1000 : 4'b0000;
                        drive(sg[0], e, pat(k), fl, md[1:0]);
                        ref_model(sg[0], e, pat(k), fl, md[1:0], ew, ef, tg);
                        check({tg, " sweep"}, out_word, out_flags, ew, ef);
                    end
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule